// File: doc/BRIEF.md
# Bitfield Move Execution Unit

This unit carries out the three bitfield-move operations of a processor's integer datapath. Each takes a source operand, a rotate immediate and a field-end immediate. The zero-fill variant clears every result bit outside the moved field. The sign-fill variant copies the field's top bit into every bit above the field. The merge variant keeps the current destination value everywhere except inside the field.

One rotate-and-mask structure covers both extraction and insertion. When the rotate immediate is at most the field-end immediate, the field starting at the rotate position is shifted down to bit 0. When the rotate immediate is larger, the low (field-end + 1) source bits are rotated right, which places them at bit position (width − rotate).

The unit works in a 64-bit or a 32-bit register size. Its result and a valid flag are registered one clock after an accepted input.

Top module: `bitfield_mover`

## Requirements
- R1: With rotate ≤ field-end and op_sel = 2'b10 (zero-fill), result[field-end − rotate : 0] equals src[field-end : rotate], and all other bits are zero. Rotate 0 with field-end 63 returns src unchanged.
- R2: With rotate > field-end and op_sel = 2'b10, the low (field-end + 1) bits of src appear starting at bit (width − rotate), and all other bits are zero.
- R3: With op_sel = 2'b00 (sign-fill), every result bit above the field equals src[field-end]. Bits below an inserted field are zero.
- R4: With op_sel = 2'b01 (merge), dst bits outside the field pass to the result unchanged, and only the field bits are replaced.
- R5: A merge insert from an all-zero source clears exactly the chosen field and leaves every other dst bit as it was.
- R6: With size_wide = 0, the operation acts on the low 32 bits, so rotation, masks and sign fill wrap at bit 31, and result[63:32] is zero.
- R7: With size_wide = 0, bit 5 set in either immediate sets illegal = 1 and gives result = 0.
- R8: op_sel = 2'b11 is reserved. It sets illegal = 1 and gives result = 0.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high. A synchronous active-high rst clears out_valid, result and illegal.
- R10: While in_valid is low, result and illegal hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 00 sign-fill, 01 merge, 10 zero-fill, 11 reserved |
| size_wide | input | 1 | 1 for 64-bit size, 0 for 32-bit size |
| src | input | XLEN | Source operand |
| dst | input | XLEN | Current destination operand, used by merge |
| rot_imm | input | 6 | Rotate-right immediate |
| end_imm | input | 6 | Field-end immediate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | XLEN | Registered result |
| illegal | output | 1 | Registered illegal-encoding flag |

## Verification
A wrong mask decode shows up in the result one clock after the input, as a field boundary moved by one or more bits. This appears as stray fill bits or as dst bits lost at the field's edges. The cases that expose it are field edges at bit 0, at the top bit and at the 32-bit wrap point. A wrong fill select shows up in that same cycle as zeros where sign copies belong, or as sign bits spilling below an inserted field. A fault in the valid or hold register appears either on the cycle after in_valid or on any idle cycle, as a pulse that is missing or out of place, or as a result that changes while no input is accepted.

// File: rtl/bfmv_pkg.sv
package bfmv_pkg;
  typedef enum logic [1:0] {
    OP_SIGNED   = 2'b00,
    OP_MERGE    = 2'b01,
    OP_UNSIGNED = 2'b10,
    OP_RSVD     = 2'b11
  } bfmv_op_e;
endpackage

// File: rtl/bfmv_ror.sv
// Rotate right within the selected register width; 32-bit mode replicates
// the low half so the low half of the output is the 32-bit rotation.
module bfmv_ror #(
  parameter int XLEN = 64,
  localparam int IMM_W = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0]  din,
  input  logic             wide,
  input  logic [IMM_W-1:0] amt,
  output logic [XLEN-1:0]  dout
);
  logic [XLEN-1:0] base;
  always_comb begin
    base = wide ? din : {din[HALF-1:0], din[HALF-1:0]};
    dout = XLEN'({base, base} >> amt);
  end
endmodule

// File: rtl/bfmv_mask_gen.sv
// Builds the write mask (field position after rotation) and the top mask
// (bits from the field's top bit down to bit 0 of the result).
module bfmv_mask_gen #(
  parameter int XLEN = 64,
  localparam int IMM_W = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic             wide,
  input  logic [IMM_W-1:0] rot,
  input  logic [IMM_W-1:0] fend,
  output logic [XLEN-1:0]  wmask,
  output logic [XLEN-1:0]  tmask
);
  logic [XLEN-1:0]  welem;
  logic [IMM_W-1:0] span;
  logic [IMM_W-1:0] mod_mask;

  always_comb begin
    mod_mask = wide ? '1 : IMM_W'(HALF - 1);
    span     = (fend - rot) & mod_mask;
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_bits
    assign welem[i] = (IMM_W'(i) <= fend);
    assign tmask[i] = (IMM_W'(i) <= span);
  end

  bfmv_ror #(.XLEN(XLEN)) u_wrot (
    .din  (welem),
    .wide (wide),
    .amt  (rot),
    .dout (wmask)
  );
endmodule

// File: rtl/bfmv_combine.sv
// Selects among rotated source, fill value and destination using the masks.
module bfmv_combine
  import bfmv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  bfmv_op_e        op,
  input  logic            wide,
  input  logic            sign,
  input  logic [XLEN-1:0] rotated,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] wmask,
  input  logic [XLEN-1:0] tmask,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] top_fill, bot_base, bot, width_mask;
  always_comb begin
    width_mask = wide ? '1 : {{HALF{1'b0}}, {HALF{1'b1}}};
    unique case (op)
      OP_MERGE:  begin top_fill = dst;            bot_base = dst; end
      OP_SIGNED: begin top_fill = {XLEN{sign}};   bot_base = '0;  end
      default:   begin top_fill = '0;             bot_base = '0;  end
    endcase
    bot = (bot_base & ~wmask) | (rotated & wmask);
    res = ((top_fill & ~tmask) | (bot & tmask)) & width_mask;
  end
endmodule

// File: rtl/bitfield_mover.sv
module bitfield_mover
  import bfmv_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int IMM_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic             size_wide,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  dst,
  input  logic [IMM_W-1:0] rot_imm,
  input  logic [IMM_W-1:0] end_imm,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             illegal
);
  logic [IMM_W-1:0] eff_rot, eff_end;
  logic [XLEN-1:0]  rotated, wmask, tmask, comb_res;
  logic             bad_enc, sign_bit;
  bfmv_op_e         op;

  always_comb begin
    op       = bfmv_op_e'(op_sel);
    eff_rot  = size_wide ? rot_imm : {1'b0, rot_imm[IMM_W-2:0]};
    eff_end  = size_wide ? end_imm : {1'b0, end_imm[IMM_W-2:0]};
    bad_enc  = (op == OP_RSVD) ||
               (!size_wide && (rot_imm[IMM_W-1] || end_imm[IMM_W-1]));
    sign_bit = src[eff_end];
  end

  bfmv_ror #(.XLEN(XLEN)) u_src_rot (
    .din  (src),
    .wide (size_wide),
    .amt  (eff_rot),
    .dout (rotated)
  );

  bfmv_mask_gen #(.XLEN(XLEN)) u_masks (
    .wide  (size_wide),
    .rot   (eff_rot),
    .fend  (eff_end),
    .wmask (wmask),
    .tmask (tmask)
  );

  bfmv_combine #(.XLEN(XLEN)) u_comb (
    .op      (op),
    .wide    (size_wide),
    .sign    (sign_bit),
    .rotated (rotated),
    .dst     (dst),
    .wmask   (wmask),
    .tmask   (tmask),
    .res     (comb_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= bad_enc ? '0 : comb_res;
        illegal <= bad_enc;
      end
    end
  end
endmodule

// File: rtl/bfmv_checker.sv
module bfmv_checker #(
  parameter int XLEN = 64,
  localparam int IMM_W = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       op_sel,
  input logic             size_wide,
  input logic [IMM_W-1:0] rot_imm,
  input logic [IMM_W-1:0] end_imm,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             illegal
);
  // R9: valid pulse follows the input strobe by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: reserved operation code
  a_r8_reserved_op: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> (illegal && result == '0));
  // R7: wide immediate in narrow mode
  a_r7_narrow_imm: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !size_wide && (rot_imm[IMM_W-1] || end_imm[IMM_W-1]))
      |=> (illegal && result == '0));
  // R6: upper half is zero in narrow mode
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !size_wide) |=> (result[XLEN-1:HALF] == '0));
  // R10: outputs hold while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

bind bitfield_mover bfmv_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .size_wide (size_wide),
  .rot_imm   (rot_imm),
  .end_imm   (end_imm),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/bitfield_mover_bench.sv
module bitfield_mover_bench;
  localparam int CLK_HALF = 10; // 50 MHz

  typedef struct packed {
    logic [1:0]  op;
    logic        wide;
    logic [5:0]  r;
    logic [5:0]  s;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] exp;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] PAT  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ELEV = 64'h1111_1111_1111_1111;
  localparam logic [63:0] ALTA = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam int NV = 16;

  localparam vec_t VECS [NV] = '{
    '{2'b10, 1'b1, 6'd8,  6'd15, PAT, ONES, 64'h0000_0000_0000_00CD, 1'b0, 8'd1}, // R1 extract
    '{2'b10, 1'b1, 6'd56, 6'd7,  PAT, ONES, 64'h0000_0000_0000_EF00, 1'b0, 8'd2}, // R2 insert
    '{2'b00, 1'b1, 6'd8,  6'd15, PAT, 64'd0, 64'hFFFF_FFFF_FFFF_FFCD, 1'b0, 8'd3}, // R3 negative
    '{2'b00, 1'b1, 6'd32, 6'd35, PAT, ONES, 64'h0000_0000_0000_0007, 1'b0, 8'd3}, // R3 positive
    '{2'b00, 1'b1, 6'd60, 6'd3,  PAT, ONES, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 8'd3}, // R3 insert
    '{2'b01, 1'b1, 6'd8,  6'd15, PAT, ELEV, 64'h1111_1111_1111_11CD, 1'b0, 8'd4}, // R4 extract
    '{2'b01, 1'b1, 6'd48, 6'd7,  PAT, ELEV, 64'h1111_1111_11EF_1111, 1'b0, 8'd4}, // R4 insert
    '{2'b01, 1'b1, 6'd52, 6'd11, 64'd0, ONES, 64'hFFFF_FFFF_FF00_0FFF, 1'b0, 8'd5}, // R5 clear
    '{2'b10, 1'b0, 6'd4,  6'd11, 64'hFFFF_FFFF_89AB_CDEF, ONES, 64'h0000_0000_0000_00DE, 1'b0, 8'd6}, // R6
    '{2'b00, 1'b0, 6'd28, 6'd3,  PAT, ONES, 64'h0000_0000_FFFF_FFF0, 1'b0, 8'd6}, // R6 sign wrap
    '{2'b01, 1'b0, 6'd24, 6'd7,  PAT, ALTA, 64'h0000_0000_AAAA_EFAA, 1'b0, 8'd6}, // R6 merge
    '{2'b10, 1'b0, 6'd32, 6'd3,  PAT, ONES, 64'd0, 1'b1, 8'd7}, // R7 rotate bit 5
    '{2'b01, 1'b0, 6'd1,  6'd33, PAT, ONES, 64'd0, 1'b1, 8'd7}, // R7 end bit 5
    '{2'b11, 1'b1, 6'd8,  6'd15, PAT, ONES, 64'd0, 1'b1, 8'd8}, // R8 reserved
    '{2'b10, 1'b1, 6'd0,  6'd63, PAT, ONES, PAT, 1'b0, 8'd1}, // R1 full width
    '{2'b10, 1'b1, 6'd63, 6'd62, PAT, ONES, 64'h0246_8ACF_1357_9BDE, 1'b0, 8'd2} // R2 shift by one
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b10;
  logic        size_wide = 1'b1;
  logic [63:0] src = '0, dst = '0;
  logic [5:0]  rot_imm = '0, end_imm = '0;
  logic        out_valid, illegal;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  bitfield_mover #(.XLEN(64)) u_bitfield_mover (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .size_wide(size_wide), .src(src), .dst(dst), .rot_imm(rot_imm),
    .end_imm(end_imm), .out_valid(out_valid), .result(result),
    .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_sel = v.op; size_wide = v.wide; rot_imm = v.r; end_imm = v.s;
    src = v.src; dst = v.dst; in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset out_valid", 64'(out_valid), 64'd0);
    check("R9 reset result", result, 64'd0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
      check($sformatf("R%0d vec %0d illegal", VECS[i].req, i), 64'(illegal), 64'(VECS[i].ill));
      check($sformatf("R9 vec %0d out_valid", i), 64'(out_valid), 64'd1);
    end

    // R10: idle inputs change, outputs hold
    @(negedge clk);
    op_sel = 2'b11; src = ONES; rot_imm = 6'd5; end_imm = 6'd9;
    repeat (2) @(negedge clk);
    check("R10 hold result", result, 64'h0246_8ACF_1357_9BDE);
    check("R10 hold illegal", 64'(illegal), 64'd0);
    check("R9 idle out_valid", 64'(out_valid), 64'd0);

    // R9 back-to-back inputs
    drive(VECS[0]);
    @(negedge clk);
    check("R1 b2b first", result, VECS[0].exp);
    drive(VECS[7]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 b2b second", result, VECS[7].exp);
    check("R9 b2b out_valid", 64'(out_valid), 64'd1);

    // R9 reset mid-run clears outputs
    drive(VECS[2]);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears out_valid", 64'(out_valid), 64'd0);
    check("R9 reset clears result", result, 64'd0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule